// File: doc/BRIEF.md
# Asynchronous Serial Transmit Framer

This block turns characters held in a transmit FIFO into asynchronous serial frames on a single output line. It reads the FIFO through a plain empty/data/pop interface. Its timing comes from an external tick that pulses once per half bit period. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period of one or one and a half bits. The line rests high between frames.

The framing options arrive as static input fields. They are captured together with the character when a frame is launched, so a change made while a frame is on the line takes effect only from the next frame. A break option forces every bit of the frame low. An optional clear-to-send input, with a selectable asserted level, holds back new frames without ever cutting a frame that has already started. A busy output is high while a frame is on the line. When another character is ready at the last tick of a stop period, the next frame follows with no idle gap.

Top module: `uart_tx_framer`

## Requirements
- R1: While in reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `fifo_pop` is 0.
- R2: `fifo_pop` is high for exactly one cycle, and only in a cycle where `half_tick` is high, `fifo_empty` is low and the transmitter is idle or on the last tick of a stop period. In the cycle after the pop, `busy` is 1 and `txd` is 0. The start bit lasts two half-bit periods.
- R3: `cfg_size` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The data bits are sent least significant bit first, and each lasts two half-bit periods.
- R4: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_mode` selects the parity: 0 gives even (the bit plus the counted bits holds an even number), 1 gives odd, 2 gives mark (always 1) and 3 gives space (always 0).
- R5: For even and odd parity, `cfg_par_zeros`=0 counts the ones among the active data bits and `cfg_par_zeros`=1 counts the zeros.
- R6: With `cfg_stop_ext`=0 the stop period is high for two half-bit periods. With `cfg_stop_ext`=1 it is high for three.
- R7: With `cfg_break`=1 at launch, `txd` is 0 for the whole frame, covering the start, data, parity and stop positions. It is 1 again once the frame ends.
- R8: With `cfg_flow_en`=1, clear-to-send counts as asserted when `cts_in` equals `cfg_cts_pol`, and no frame launches while it is deasserted. With `cfg_flow_en`=0, `cts_in` has no effect.
- R9: If clear-to-send is deasserted during a frame, that frame still completes unchanged and the following character stays in the FIFO.
- R10: `busy` stays high from the cycle after a pop until the end of the stop period. When a character is ready at the final stop tick, the next frame starts at once with no idle period between frames.
- R11: Configuration is captured at launch. Changing the fields during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One-cycle pulse at twice the bit rate |
| fifo_empty | input | 1 | Transmit FIFO holds no character |
| fifo_data | input | MAX_DATA | Character at the FIFO head |
| fifo_pop | output | 1 | Takes the head character (combinational) |
| cfg_size | input | SIZE_W | Data length select, 0..3 gives 5..8 bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_mode | input | 2 | 0 even, 1 odd, 2 mark, 3 space |
| cfg_par_zeros | input | 1 | Parity counts zeros instead of ones |
| cfg_stop_ext | input | 1 | Stop period of 1.5 bits |
| cfg_break | input | 1 | Send an all-low frame |
| cfg_flow_en | input | 1 | Clear-to-send gating enable |
| cfg_cts_pol | input | 1 | Level of `cts_in` that means asserted |
| cts_in | input | 1 | Clear-to-send from the far end |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A frame is on the line |

## Verification
`fifo_pop` is decoded in the same cycle as the tick that launches a frame. The bench predicts it at the falling edge before that clock edge, using the bench's own view of the FIFO, the tick and clear-to-send. `txd` and `busy` change on the clock edge that takes the pop, and every half-bit period after that lasts exactly one tick interval. The bench therefore counts falling edges from the launch and samples each half-bit position in its middle, half a tick interval into it. At that point it compares the line against a frame it built from the captured character and fields. While no frame is open, the line level and the idle `busy` are checked on every tick cycle. Gating and flow cases are checked after a pause long enough for a frame to have appeared.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } txf_state_e;

   typedef enum logic [1:0] {
      PM_EVEN  = 2'd0,
      PM_ODD   = 2'd1,
      PM_MARK  = 2'd2,
      PM_SPACE = 2'd3
   } txf_par_mode_e;

endpackage

// File: rtl/uart_txf_parity.sv
module uart_txf_parity
   import uart_txf_pkg::*;
#(
   parameter int MAX_DATA = 8,
   parameter int SIZE_W   = 2
) (
   input  logic [MAX_DATA-1:0] data,
   input  logic [SIZE_W-1:0]   size,
   input  logic [1:0]          mode,
   input  logic                count_zeros,
   output logic                par_bit
);
   localparam int MIN_DATA = MAX_DATA - (1 << SIZE_W) + 1;
   localparam int NB_W     = $clog2(MAX_DATA + 1);

   logic [NB_W-1:0]     n_bits;
   logic [MAX_DATA-1:0] mask;
   logic                ones_odd;
   logic                cnt_odd;

   assign n_bits = NB_W'(MIN_DATA) + NB_W'(size);

   // active-bit mask, one comparator per data position
   for (genvar i = 0; i < MAX_DATA; i++) begin : g_mask
      assign mask[i] = (NB_W'(i) < n_bits);
   end

   assign ones_odd = ^(data & mask);
   // zeros = n - ones, so its lsb flips with the lsb of n
   assign cnt_odd  = count_zeros ? (ones_odd ^ n_bits[0]) : ones_odd;

   always_comb begin
      unique case (txf_par_mode_e'(mode))
         PM_EVEN:  par_bit = cnt_odd;
         PM_ODD:   par_bit = ~cnt_odd;
         PM_MARK:  par_bit = 1'b1;
         default:  par_bit = 1'b0;
      endcase
   end

   initial begin
      assert (MIN_DATA >= 1) else $error("SIZE_W too wide for MAX_DATA");
   end
endmodule

// File: rtl/uart_txf_bittimer.sv
module uart_txf_bittimer #(
   parameter int HALVES_PER_BIT = 2,
   parameter int LONG_HALVES    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic active,
   input  logic half_tick,
   input  logic long_bit,
   output logic last_half,
   output logic bit_end
);
   localparam int CW = (LONG_HALVES > 1) ? $clog2(LONG_HALVES) : 1;

   logic [CW-1:0] hc_q;
   logic [CW-1:0] last_val;

   if (LONG_HALVES == HALVES_PER_BIT) begin : g_flat
      assign last_val = CW'(HALVES_PER_BIT - 1);
   end else begin : g_ext
      assign last_val = long_bit ? CW'(LONG_HALVES - 1) : CW'(HALVES_PER_BIT - 1);
   end

   assign last_half = (hc_q == last_val);
   assign bit_end   = active && half_tick && last_half;

   always_ff @(posedge clk) begin
      if (!rst_n)                   hc_q <= '0;
      else if (restart)             hc_q <= '0;
      else if (active && half_tick) hc_q <= last_half ? '0 : hc_q + 1'b1;
   end

   a_r6_half_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      hc_q <= CW'(LONG_HALVES - 1));

   a_r6_idle_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (hc_q == '0));

   initial begin
      assert (LONG_HALVES >= HALVES_PER_BIT && HALVES_PER_BIT >= 1)
         else $error("stop halves must not be shorter than a bit");
   end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
   import uart_txf_pkg::*;
#(
   parameter int MAX_DATA        = 8,
   parameter int SIZE_W          = 2,
   parameter int HALVES_PER_BIT  = 2,
   parameter int STOP_EXT_HALVES = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                half_tick,
   input  logic                fifo_empty,
   input  logic [MAX_DATA-1:0] fifo_data,
   output logic                fifo_pop,
   input  logic [SIZE_W-1:0]   cfg_size,
   input  logic                cfg_par_en,
   input  logic [1:0]          cfg_par_mode,
   input  logic                cfg_par_zeros,
   input  logic                cfg_stop_ext,
   input  logic                cfg_break,
   input  logic                cfg_flow_en,
   input  logic                cfg_cts_pol,
   input  logic                cts_in,
   output logic                txd,
   output logic                busy
);
   localparam int MIN_DATA = MAX_DATA - (1 << SIZE_W) + 1;
   localparam int NB_W     = $clog2(MAX_DATA + 1);
   localparam int IDX_W    = (MAX_DATA > 1) ? $clog2(MAX_DATA) : 1;

   txf_state_e          state_q;
   logic [MAX_DATA-1:0] shreg_q;
   logic [IDX_W-1:0]    bitcnt_q;
   logic [NB_W-1:0]     nbits_q;
   logic                par_en_q, par_bit_q, stop_ext_q, brk_q;

   logic cts_ok, can_launch, last_half, bit_end, par_now, last_data;

   assign busy       = (state_q != ST_IDLE);
   assign cts_ok     = !cfg_flow_en || (cts_in == cfg_cts_pol);
   assign can_launch = (state_q == ST_IDLE) || ((state_q == ST_STOP) && last_half);
   assign fifo_pop   = half_tick && !fifo_empty && cts_ok && can_launch;
   assign last_data  = (NB_W'(bitcnt_q) == nbits_q - NB_W'(1));

   uart_txf_parity #(.MAX_DATA(MAX_DATA), .SIZE_W(SIZE_W)) u_parity (
      .data        (fifo_data),
      .size        (cfg_size),
      .mode        (cfg_par_mode),
      .count_zeros (cfg_par_zeros),
      .par_bit     (par_now)
   );

   uart_txf_bittimer #(.HALVES_PER_BIT(HALVES_PER_BIT), .LONG_HALVES(STOP_EXT_HALVES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (fifo_pop),
      .active    (busy),
      .half_tick (half_tick),
      .long_bit  ((state_q == ST_STOP) && stop_ext_q),
      .last_half (last_half),
      .bit_end   (bit_end)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         shreg_q    <= '0;
         bitcnt_q   <= '0;
         nbits_q    <= '0;
         par_en_q   <= 1'b0;
         par_bit_q  <= 1'b0;
         stop_ext_q <= 1'b0;
         brk_q      <= 1'b0;
      end else if (fifo_pop) begin
         state_q    <= ST_START;
         shreg_q    <= fifo_data;
         bitcnt_q   <= '0;
         nbits_q    <= NB_W'(MIN_DATA) + NB_W'(cfg_size);
         par_en_q   <= cfg_par_en;
         par_bit_q  <= par_now;
         stop_ext_q <= cfg_stop_ext;
         brk_q      <= cfg_break;
      end else if (bit_end) begin
         unique case (state_q)
            ST_START: state_q <= ST_DATA;
            ST_DATA: begin
               shreg_q <= shreg_q >> 1;
               if (last_data) state_q  <= par_en_q ? ST_PAR : ST_STOP;
               else           bitcnt_q <= bitcnt_q + 1'b1;
            end
            ST_PAR:  state_q <= ST_STOP;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      if (state_q == ST_IDLE) txd = 1'b1;
      else if (brk_q)         txd = 1'b0;
      else begin
         unique case (state_q)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg_q[0];
            ST_PAR:   txd = par_bit_q;
            default:  txd = 1'b1;
         endcase
      end
   end

   a_r2_pop_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (half_tick && !fifo_empty));

   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |=> (busy && !txd));

   a_r8_pop_needs_cts: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && cfg_flow_en) |-> (cts_in == cfg_cts_pol));

   a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   a_r7_break_low: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && brk_q) |-> !txd);

   a_r3_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA) |-> (NB_W'(bitcnt_q) < nbits_q));

   a_r11_frame_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fifo_pop) |=> ($stable(nbits_q) && $stable(par_en_q) && $stable(brk_q)));

   initial begin
      assert (MIN_DATA >= 1 && MAX_DATA >= 2) else $error("bad data width parameters");
   end
endmodule

// File: tb/uart_tx_framer_bench.sv
module uart_tx_framer_bench;
   localparam int TICK_DIV = 4;
   localparam int HALF     = TICK_DIV / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic half_tick = 1'b0;
   int   tcnt = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         tcnt <= 0; half_tick <= 1'b0;
      end else begin
         tcnt      <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
         half_tick <= (tcnt == TICK_DIV - 1);
      end
   end

   logic [7:0] mem [0:63];
   int wr_ptr = 0;
   int rd_ptr = 0;
   logic fifo_empty, fifo_pop, txd, busy;
   logic [7:0] fifo_data;
   assign fifo_empty = (rd_ptr == wr_ptr);
   assign fifo_data  = mem[rd_ptr % 64];
   always @(posedge clk) if (fifo_pop === 1'b1) rd_ptr <= rd_ptr + 1;

   logic [1:0] cfg_size = 2'd3;
   logic       cfg_par_en = 0, cfg_par_zeros = 0, cfg_stop_ext = 0, cfg_break = 0;
   logic [1:0] cfg_par_mode = 2'd0;
   logic       cfg_flow_en = 0, cfg_cts_pol = 0, cts_in = 0;

   uart_tx_framer u_uart_tx_framer (
      .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
      .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
      .cfg_size(cfg_size), .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
      .cfg_par_zeros(cfg_par_zeros), .cfg_stop_ext(cfg_stop_ext), .cfg_break(cfg_break),
      .cfg_flow_en(cfg_flow_en), .cfg_cts_pol(cfg_cts_pol), .cts_in(cts_in),
      .txd(txd), .busy(busy)
   );

   int checks = 0;
   int failures = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp, input string what);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic int frame_halves(int size, bit pen, bit sext);
      return 2 * (1 + 5 + size + (pen ? 1 : 0)) + (sext ? 3 : 2);
   endfunction

   function automatic bit exp_slot(logic [7:0] d, int size, bit pen, int pmode, bit pz,
                                   bit brk, int slot);
      int n = 5 + size;
      int b = slot / 2;
      int ones = 0;
      int cnt;
      if (brk) return 1'b0;
      if (b == 0) return 1'b0;
      if (b <= n) return d[b-1];
      if (pen && b == n + 1) begin
         for (int i = 0; i < n; i++) ones += int'(d[i]);
         cnt = pz ? (n - ones) : ones;
         case (pmode)
            0: return bit'(cnt % 2);
            1: return bit'(1 - cnt % 2);
            2: return 1'b1;
            default: return 1'b0;
         endcase
      end
      return 1'b1;
   endfunction

   function automatic string slot_tag(int size, bit pen, bit pz, bit brk, int slot);
      int b = slot / 2;
      if (brk) return "R7";
      if (b == 0) return "R2";
      if (b <= 5 + size) return "R3";
      if (pen && b == 6 + size) return pz ? "R5" : "R4";
      return "R6";
   endfunction

   // frame monitor
   bit in_frame = 0;
   int idx = 0, flen = 0;
   logic [7:0] f_d;
   int  f_size, f_pmode;
   bit  f_pen, f_pz, f_brk;
   bit  ending, exp_pop, cts_ok_b, e;
   string tag;

   always @(negedge clk) begin
      if (!rst_n) begin
         in_frame = 0;
      end else begin
         if (in_frame && (idx % TICK_DIV) == HALF) begin
            e   = exp_slot(f_d, f_size, f_pen, f_pmode, f_pz, f_brk, idx / TICK_DIV);
            tag = slot_tag(f_size, f_pen, f_pz, f_brk, idx / TICK_DIV);
            check(txd === e && busy === 1'b1, tag, {busy, txd}, {1'b1, e}, "frame half-bit");
         end
         if (!in_frame && half_tick)
            check(txd === 1'b1 && busy === 1'b0, "R1", {busy, txd}, 1, "idle line");
         ending   = in_frame && (idx == flen * TICK_DIV - 1);
         cts_ok_b = !cfg_flow_en || (cts_in == cfg_cts_pol);
         exp_pop  = (!in_frame || ending) && half_tick && !fifo_empty && cts_ok_b;
         if (exp_pop || fifo_pop === 1'b1)
            check(fifo_pop === exp_pop, ending ? "R10" : (cfg_flow_en ? "R8" : "R2"),
                  int'(fifo_pop), int'(exp_pop), "pop timing");
         if (fifo_pop === 1'b1) begin
            f_d = fifo_data; f_size = int'(cfg_size); f_pen = cfg_par_en;
            f_pmode = int'(cfg_par_mode); f_pz = cfg_par_zeros; f_brk = cfg_break;
            flen = frame_halves(f_size, f_pen, cfg_stop_ext);
            in_frame = 1; idx = 0;
         end else if (ending) in_frame = 0;
         else if (in_frame) idx++;
      end
   end

   task automatic set_cfg(int size, bit pen, int pmode, bit pz, bit sext, bit brk);
      @(posedge clk); #1;
      cfg_size = 2'(size); cfg_par_en = pen; cfg_par_mode = 2'(pmode);
      cfg_par_zeros = pz; cfg_stop_ext = sext; cfg_break = brk;
   endtask

   task automatic push(logic [7:0] d);
      @(posedge clk); #1;
      mem[wr_ptr % 64] = d; wr_ptr++;
   endtask

   task automatic drain();
      do @(negedge clk); while (!(rd_ptr == wr_ptr && busy === 1'b0));
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_busy();
      do @(negedge clk); while (busy !== 1'b1);
   endtask

   int cnt, fsnap;

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
      void'($urandom(32'd5150));
      repeat (4) @(negedge clk);
      check(txd === 1'b1 && busy === 1'b0 && fifo_pop === 1'b0, "R1", {busy, txd}, 1, "in reset");
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (12) @(negedge clk);
      check(txd === 1'b1 && busy === 1'b0 && fifo_pop === 1'b0, "R1", {busy, txd}, 1, "after reset");

      // R3: 8 and 5 bit characters, no parity
      set_cfg(3, 0, 0, 0, 0, 0); push(8'hA5); drain();
      set_cfg(0, 0, 0, 0, 0, 0); push(8'h16); drain();
      // R4 / R5: each parity mode, both count senses
      for (int m = 0; m < 4; m++) begin
         for (int z = 0; z < 2; z++) begin
            set_cfg(m % 4, 1, m, bit'(z), 0, 0); push(8'h5B); push(8'h00); drain();
         end
      end
      // R6: long stop
      set_cfg(2, 1, 1, 0, 1, 0); push(8'h7F); push(8'h01); drain();
      // R7: break frame, then normal again
      set_cfg(3, 1, 2, 0, 1, 1); push(8'hFF); drain();
      set_cfg(3, 0, 0, 0, 0, 0); push(8'hC3); drain();

      // R10: three back-to-back frames, 20 half-bits each
      push(8'h11); push(8'h22); push(8'h33);
      wait_busy();
      cnt = 0;
      while (busy === 1'b1) begin cnt++; @(negedge clk); end
      check(cnt == 3 * 20 * TICK_DIV, "R10", cnt, 3 * 20 * TICK_DIV, "busy span of 3 frames");
      drain();

      // R8: flow gating, asserted level = 1
      @(posedge clk); #1 cfg_flow_en = 1; cfg_cts_pol = 1; cts_in = 0;
      push(8'h42);
      repeat (60) @(negedge clk);
      check(busy === 1'b0 && txd === 1'b1 && (wr_ptr - rd_ptr) == 1, "R8",
            wr_ptr - rd_ptr, 1, "held while cts deasserted");
      @(posedge clk); #1 cts_in = 1;
      drain();
      check(rd_ptr == wr_ptr, "R8", wr_ptr - rd_ptr, 0, "sent after cts asserted");

      // R9: deassert mid-frame, asserted level = 0
      @(posedge clk); #1 cfg_cts_pol = 0; cts_in = 0;
      push(8'h9A); push(8'h6C);
      wait_busy();
      @(posedge clk); #1 cts_in = 1;
      repeat (150) @(negedge clk);
      check(busy === 1'b0 && txd === 1'b1 && (wr_ptr - rd_ptr) == 1, "R9",
            wr_ptr - rd_ptr, 1, "frame finished, next held");
      @(posedge clk); #1 cts_in = 0;
      drain();

      // R8: flow disabled ignores cts
      @(posedge clk); #1 cfg_flow_en = 0; cfg_cts_pol = 1; cts_in = 0;
      push(8'h3E);
      drain();
      check(rd_ptr == wr_ptr, "R8", wr_ptr - rd_ptr, 0, "cts ignored when flow off");

      // R11: fields change mid-frame
      set_cfg(3, 0, 0, 0, 0, 0);
      fsnap = failures;
      push(8'h3C);
      wait_busy();
      set_cfg(0, 1, 1, 1, 1, 1);
      do @(negedge clk); while (busy === 1'b1);
      check(failures == fsnap, "R11", failures - fsnap, 0, "frame kept launch config");
      repeat (4) @(negedge clk);

      // random configurations
      for (int it = 0; it < 40; it++) begin
         set_cfg(int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                 bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
         for (int k = 0; k <= int'($urandom_range(0, 2)); k++) push(8'($urandom()));
         drain();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule